// File: doc/BRIEF.md
# Byte-Wide Flash Read Width Adapter

This block lets a 32-bit memory-mapped read master fetch words from a parallel flash that returns one byte per access. The master raises a read request with an address. The adapter clears the two low address bits and runs four byte reads in a row, one at each byte address of that word. It then returns the four bytes as a single 32-bit word.

The master is held off by a wait output until the word is ready. The wait output drops for exactly one clock cycle, and the word is valid only in that cycle. The consumer must capture the word on the rising clock edge at which wait is sampled low. It must not react to a transition of the wait line itself.

The controller has three states:
- IDLE: waits for a request. A request moves it to ACCESS (accept).
- ACCESS: holds each byte address and the read strobe for `LAT` cycles, then samples the byte. After the fourth byte it moves to DONE (last capture).
- DONE: presents the word with wait low. It always returns to IDLE on the next edge (release).

Top module: `flash_word_reader`

## Requirements
- R1: Each accepted request produces four flash accesses at byte addresses base, base+1, base+2 and base+3, in ascending order. The read strobe stays high continuously across all four accesses.
- R2: The two least significant bits of the request address have no effect: base is the request address with bits 1:0 cleared.
- R3: The returned word is packed big-endian. The byte from base goes to bits 31:24, base+1 to 23:16, base+2 to 15:8 and base+3 to 7:0.
- R4: Each byte access holds its address for exactly `LAT` cycles (default 3), and the byte is sampled at the end of that window. Wait is high for 4*`LAT` cycles after the accepting edge, and the read strobe is low whenever wait is low.
- R5: Wait is low for exactly one cycle per request, and the packed word is valid in that cycle.
- R6: The request address is latched when the request is accepted. Changes on the request address during a transfer do not alter the flash addresses or the returned word.
- R7: A synchronous active-high reset, even in the middle of a transfer, returns the adapter to IDLE. After reset the read strobe is low and wait is high. A following request completes normally.
- R8: From DONE the adapter always passes through IDLE. A request held high across the completion edge is therefore accepted one edge later: wait stays high for 4*`LAT`+1 cycles before the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rd | input | 1 | Master read request |
| req_addr | input | ADDR_W | Master byte address (bits 1:0 ignored) |
| req_wait | output | 1 | Stall; low for one cycle when the word is valid |
| req_data | output | 32 | Packed read word |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_rd | output | 1 | Flash read strobe |
| fl_data | input | 8 | Byte returned by the flash |

## Verification
Two events can fall in the same cycle: the one-cycle completion window of one word, and the arrival of the next request. The bench provokes this by keeping the request high and changing the address in the DONE cycle. It then checks two things: the first word is captured in that cycle, and the second word arrives after exactly one extra idle cycle with its own data. The bench also changes the request address in the middle of a transfer, and resets the adapter in the middle of a transfer. Results are judged against words computed from a byte model of the flash.

// File: rtl/fwr_pkg.sv
package fwr_pkg;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int LANE_W = $clog2(LANES);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_DONE   = 2'd2
    } fwr_state_e;
endpackage

// File: rtl/fwr_ctrl.sv
module fwr_ctrl
    import fwr_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_rd,
    output fwr_state_e        state,
    output logic [LANE_W-1:0] lane,
    output logic              accept,
    output logic              capture
);
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

    fwr_state_e        state_q;
    logic [CW-1:0]     cnt_q;
    logic [LANE_W-1:0] lane_q;
    logic              win_end;
    logic              last_lane;

    always_comb begin
        win_end   = (cnt_q == CW'(LAT - 1));
        last_lane = (lane_q == LANE_W'(LANES - 1));
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            lane_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q  <= '0;
                    lane_q <= '0;
                    if (req_rd) state_q <= ST_ACCESS;
                end
                ST_ACCESS: begin
                    if (win_end) begin
                        cnt_q <= '0;
                        if (last_lane) state_q <= ST_DONE;
                        else           lane_q  <= lane_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        accept  = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE:   accept  = req_rd;
            ST_ACCESS: capture = win_end;
            ST_DONE:   ;
            default:   ;
        endcase
        state = state_q;
        lane  = lane_q;
    end
endmodule

// File: rtl/fwr_addr_gen.sv
module fwr_addr_gen
    import fwr_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANE_W-1:0] lane,
    output logic [ADDR_W-1:0] fl_addr
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(LANES - 1);

    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst)         base_q <= '0;
        else if (accept) base_q <= req_addr & ~LOW_MASK;
    end

    // base_q low bits are always zero, so OR forms base + lane
    assign fl_addr = base_q | ADDR_W'(lane);
endmodule

// File: rtl/fwr_packer.sv
module fwr_packer
    import fwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [LANE_W-1:0] lane,
    input  logic [BYTE_W-1:0] fl_data,
    output logic [WORD_W-1:0] word
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [BYTE_W-1:0] byte_q;
        always_ff @(posedge clk) begin
            if (rst)                                  byte_q <= '0;
            else if (capture && lane == LANE_W'(i))   byte_q <= fl_data;
        end
        // lowest byte address lands in the most significant byte
        assign word[WORD_W-1-i*BYTE_W -: BYTE_W] = byte_q;
    end
endmodule

// File: rtl/flash_word_reader.sv
module flash_word_reader
    import fwr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LAT    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_rd,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_wait,
    output logic [31:0]       req_data,
    output logic [ADDR_W-1:0] fl_addr,
    output logic              fl_rd,
    input  logic [7:0]        fl_data
);
    fwr_state_e        state;
    logic [LANE_W-1:0] lane;
    logic              accept;
    logic              capture;

    fwr_ctrl #(.LAT(LAT)) ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .req_rd  (req_rd),
        .state   (state),
        .lane    (lane),
        .accept  (accept),
        .capture (capture)
    );

    fwr_addr_gen #(.ADDR_W(ADDR_W)) addr_i (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .req_addr (req_addr),
        .lane     (lane),
        .fl_addr  (fl_addr)
    );

    fwr_packer pack_i (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .lane    (lane),
        .fl_data (fl_data),
        .word    (req_data)
    );

    always_comb begin
        req_wait = (state != ST_DONE);
        fl_rd    = (state == ST_ACCESS);
    end
endmodule

// File: rtl/fwr_checker.sv
module fwr_checker #(
    parameter int ADDR_W = 24,
    parameter int LAT    = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              req_wait,
    input logic              fl_rd,
    input logic [ADDR_W-1:0] fl_addr
);
    logic [15:0]       run_q;
    logic              prev_rd_q;
    logic [ADDR_W-1:0] prev_addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q       <= '0;
            prev_rd_q   <= 1'b0;
            prev_addr_q <= '0;
        end else begin
            prev_rd_q   <= fl_rd;
            prev_addr_q <= fl_addr;
            if (!fl_rd)                                   run_q <= '0;
            else if (!prev_rd_q || fl_addr != prev_addr_q) run_q <= 16'd1;
            else                                          run_q <= run_q + 16'd1;
        end
    end

    AST_WORD_FIXED: assert property (@(posedge clk) disable iff (rst)
        (fl_rd && $past(fl_rd) && !$past(rst)) |-> fl_addr[ADDR_W-1:2] == $past(fl_addr[ADDR_W-1:2])); // R1
    AST_LANE_STEP: assert property (@(posedge clk) disable iff (rst)
        (fl_rd && $past(fl_rd) && !$past(rst) && fl_addr != $past(fl_addr))
            |-> fl_addr[1:0] == $past(fl_addr[1:0]) + 2'd1); // R1
    AST_HOLD_LAT: assert property (@(posedge clk) disable iff (rst)
        (fl_rd && $past(fl_rd) && !$past(rst) && fl_addr != $past(fl_addr)) |-> run_q == 16'(LAT)); // R4
    AST_LAST_LAT: assert property (@(posedge clk) disable iff (rst)
        (!fl_rd && $past(fl_rd) && !$past(rst)) |-> run_q == 16'(LAT)); // R4
    AST_STROBE_OFF: assert property (@(posedge clk) disable iff (rst)
        !req_wait |-> !fl_rd); // R4
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !req_wait |=> req_wait); // R5
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (req_wait && !fl_rd)); // R7
endmodule

bind flash_word_reader fwr_checker #(.ADDR_W(ADDR_W), .LAT(LAT)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .req_wait (req_wait),
    .fl_rd    (fl_rd),
    .fl_addr  (fl_addr)
);

// File: tb/flash_word_reader_tb_top.sv
module flash_word_reader_tb_top;
    localparam int AW  = 24;
    localparam int LAT = 3;
    localparam int NV  = 6;

    // {request address, expected aligned base}
    localparam logic [2*AW-1:0] VEC [NV] = '{
        {24'h000000, 24'h000000},
        {24'h000001, 24'h000000},
        {24'h000106, 24'h000104},
        {24'h0ABCDF, 24'h0ABCDC},
        {24'hFFFFFE, 24'hFFFFFC},
        {24'h000013, 24'h000010}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_rd = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_wait;
    logic [31:0]   req_data;
    logic [AW-1:0] fl_addr;
    logic          fl_rd;
    logic [7:0]    fl_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [7:0] fbyte(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    function automatic logic [31:0] exp_word(input logic [AW-1:0] b);
        return {fbyte(b), fbyte(b + 1), fbyte(b + 2), fbyte(b + 3)};
    endfunction

    // byte-wide flash model
    assign fl_data = fl_rd ? fbyte(fl_addr) : 8'hEE;

    flash_word_reader #(.ADDR_W(AW), .LAT(LAT)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .req_rd   (req_rd),
        .req_addr (req_addr),
        .req_wait (req_wait),
        .req_data (req_data),
        .fl_addr  (fl_addr),
        .fl_rd    (fl_rd),
        .fl_data  (fl_data)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One read; optionally disturb the address mid-transfer.
    task automatic run_read(input logic [AW-1:0] a, input logic [AW-1:0] b,
                            input bit disturb, input string tag);
        int highs = 0;
        bit seq_ok = 1'b1;
        @(negedge clk);
        req_rd   = 1'b1;
        req_addr = a;
        do begin
            @(negedge clk);
            if (req_wait) begin
                highs++;
                if (!fl_rd || fl_addr !== b + AW'((highs - 1) / LAT)) seq_ok = 1'b0;
                if (disturb && highs == 5) req_addr = ~a;
            end
        end while (req_wait && highs < 100);
        check(highs == 4 * LAT, {tag, " R4 wait cycles"}, 64'(highs), 64'(4 * LAT));
        check(seq_ok, {tag, " R1 byte address sequence"}, 64'(seq_ok), 64'd1);
        check(req_data === exp_word(b), {tag, " R3/R2 packed word"},
              64'(req_data), 64'(exp_word(b)));
        req_rd = 1'b0;
        @(negedge clk);
        check(req_wait === 1'b1, {tag, " R5 single-cycle window"}, 64'(req_wait), 64'd1);
    endtask

    initial begin
        int highs;
        repeat (3) @(negedge clk);
        // R7 reset state
        check(req_wait === 1'b1 && fl_rd === 1'b0, "R7 reset state",
              64'({req_wait, fl_rd}), 64'b10);
        rst = 1'b0;

        for (int i = 0; i < NV; i++)
            run_read(VEC[i][2*AW-1:AW], VEC[i][AW-1:0], 1'b0, $sformatf("vec%0d", i));

        // R6: address change during transfer ignored
        run_read(24'h123457, 24'h123454, 1'b1, "R6 disturb");

        // R8: request held across completion, new address in DONE cycle
        @(negedge clk);
        req_rd = 1'b1;
        req_addr = 24'h00200A;
        do @(negedge clk); while (req_wait);
        check(req_data === exp_word(24'h002008), "R8 first word",
              64'(req_data), 64'(exp_word(24'h002008)));
        req_addr = 24'h00300D;
        highs = 0;
        do begin
            @(negedge clk);
            if (req_wait) highs++;
        end while (req_wait && highs < 100);
        check(highs == 4 * LAT + 1, "R8 back-to-back wait cycles", 64'(highs), 64'(4 * LAT + 1));
        check(req_data === exp_word(24'h00300C), "R8 second word",
              64'(req_data), 64'(exp_word(24'h00300C)));
        req_rd = 1'b0;
        @(negedge clk);

        // R7: reset in mid-transfer
        req_rd = 1'b1;
        req_addr = 24'h000400;
        repeat (5) @(negedge clk);
        req_rd = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(req_wait === 1'b1 && fl_rd === 1'b0, "R7 mid-transfer reset",
              64'({req_wait, fl_rd}), 64'b10);
        rst = 1'b0;
        run_read(24'h000502, 24'h000500, 1'b0, "R7 after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule